// File: doc/BRIEF.md
# Memory Pattern Self-Test Engine

This block runs a fixed three-phase self-test against a simple word-addressed memory port. A single `start` pulse launches the run. The engine first toggles every data line with two alternating bit patterns over a small window. Next, it fills a larger window with a pseudo-random 32-bit stream and checks it by regenerating the same stream. Last, it writes each iteration's index to an address chosen by a 16-bit generator and reads those addresses back in the same order. When the same index comes back, no two generated addresses alias onto one storage word.

Each phase has its own saturating mismatch counter. When the run ends, `done` rises and `pass` reports whether all three counters are zero. The counters, `done` and `pass` then hold their values until the next start. The memory sees at most one access per cycle and at most one outstanding read. A read returns whenever `mem_rvalid` arrives, so any read latency of one cycle or more is accepted.

The controller is a single state machine with these states: IDLE, BUS_WR, BUS_RQ, BUS_WT, DAT_WR, DAT_RQ, DAT_WT, ADR_WR, ADR_RQ, ADR_WT and DONE.
- IDLE or DONE go to BUS_WR on start.
- Each `*_WR` state steps its index and goes to its `*_RQ` state after the last write.
- Each `*_RQ` state issues one read and goes to its `*_WT` state.
- Each `*_WT` state waits for read data. It goes back to its `*_RQ` state until the last word.
- After the last word:
  - BUS_WT goes to BUS_WR for the second pattern, then to DAT_WR.
  - DAT_WT goes to ADR_WR.
  - ADR_WT goes to DONE.

Top module: `mem_bist_engine`

## Requirements
- R1: A `start` pulse while IDLE or DONE clears all three error counts and begins a run. `start` during a run is ignored. `done` is low during a run and rises once all phases end. `done`, `pass` and the counts then stay unchanged until the next `start`.
- R2: `mem_we` and `mem_re` are never high in the same cycle. A new read is never issued while a read is outstanding. Each run performs exactly 2*BUS_WORDS + DATA_WORDS + ADDR_ITERS writes and the same number of reads.
- R3: The bus phase writes 0xAAAAAAAA to word addresses 0 to BUS_WORDS-1 and reads them back in ascending order. It then repeats the fill and readback with 0x55555555. Each differing word adds one to the bus count.
- R4: The data phase writes value x(i+1) to word i, for i from 0 to DATA_WORDS-1. Here x(0)=0 and x(k+1) = (1664525*x(k) + 1013904223) mod 2^32, so the first data write is 0x3C6EF35F at address 0. Readback regenerates the stream, and each differing word adds one to the data count.
- R5: Address phase, write pass: iteration i (from 0) advances a 16-bit generator a from a(0)=0 and writes the 32-bit index i at word address a(i+1), zero-extended. Read pass: the generator restarts at 0 and revisits the addresses in the same order. Each read whose low 16 bits differ from i[15:0] adds one to the address count.
- R6: With `addr_rand` low when `start` is sampled, the generator uses a+1, so the first address-phase write is index 0 at address 1. With it high, the generator uses (25173*a + 13849) mod 2^16, so the first write is index 0 at address 13849.
- R7: Each error count saturates at 2^ERR_W-1 and never wraps.
- R8: `pass` is high only while `done` is high and all three counts are zero.
- R9: After reset, `done`, `pass`, `mem_we`, `mem_re` and all counts are zero.
- R10: The phases run in the order bus, data, address. All writes of a phase precede that phase's reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run launch pulse |
| addr_rand | input | 1 | Address generator mode, sampled at start (1 = pseudo-random) |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 32 | Write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read request |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid |
| done | output | 1 | Run complete |
| pass | output | 1 | Run complete with no errors |
| err_bus | output | ERR_W | Bus phase mismatch count |
| err_data | output | ERR_W | Data phase mismatch count |
| err_addr | output | ERR_W | Address phase mismatch count |

## Verification
Most faults in the state machine or generators show up at the ports in two ways: a changed number of writes or reads per run, or the wrong first value written in a phase. The bench watches both from the first access of each phase. A generator that fails to reload between write and read passes would make a clean memory score nearly every word as an error, so the error counts expose it at `done`. Injected stuck data bits, address aliasing and single-word corruption are scored against counts the bench derives from the requirements. A saturation or hold fault then shows up at `done` and in the cycles after it.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BUS_WR, ST_BUS_RQ, ST_BUS_WT,
        ST_DAT_WR, ST_DAT_RQ, ST_DAT_WT,
        ST_ADR_WR, ST_ADR_RQ, ST_ADR_WT,
        ST_DONE
    } bist_state_e;

    localparam logic [31:0] TOGGLE_LO = 32'hAAAAAAAA;
    localparam logic [31:0] TOGGLE_HI = 32'h55555555;

    localparam logic [31:0] DGEN_MUL = 32'd1664525;
    localparam logic [31:0] DGEN_ADD = 32'd1013904223;
    localparam logic [15:0] AGEN_MUL = 16'd25173;
    localparam logic [15:0] AGEN_ADD = 16'd13849;

    function automatic logic [31:0] data_next(input logic [31:0] x);
        return DGEN_MUL * x + DGEN_ADD;
    endfunction

    function automatic logic [15:0] addr_next(input logic [15:0] x, input logic rnd);
        return rnd ? (AGEN_MUL * x + AGEN_ADD) : (x + 16'd1);
    endfunction

endpackage

// File: rtl/mbist_errcnt.sv
module mbist_errcnt #(
    parameter int ERR_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [ERR_W-1:0] cnt
);
    localparam logic [ERR_W-1:0] CNT_MAX = {ERR_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (clr)           cnt <= '0;
        else if (inc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    // R7: never wraps back to a smaller value without a clear
    p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> cnt >= $past(cnt));

    // R7: a full counter stays full
    p_hold_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);

endmodule

// File: rtl/mbist_patgen.sv
module mbist_patgen (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic        step,
    input  logic        rnd,
    output logic [31:0] dval,
    output logic [15:0] aval
);
    import mbist_pkg::*;

    logic [31:0] dstate;
    logic [15:0] astate;

    assign dval = data_next(dstate);
    assign aval = addr_next(astate, rnd);

    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            dstate <= '0;
            astate <= '0;
        end else if (step) begin
            dstate <= dval;
            astate <= aval;
        end
    end

endmodule

// File: rtl/mbist_fsm.sv
module mbist_fsm #(
    parameter int BUS_WORDS  = 128,
    parameter int DATA_WORDS = 524288,
    parameter int ADDR_ITERS = 8192,
    parameter int IDX_W      = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    rvalid,
    output mbist_pkg::bist_state_e  state,
    output logic [IDX_W-1:0]        idx,
    output logic                    hi_pat,
    output logic                    wr_o,
    output logic                    rd_o,
    output logic                    load_o,
    output logic                    step_o,
    output logic                    clr_o
);
    import mbist_pkg::*;

    localparam logic [IDX_W-1:0] BUS_LAST = IDX_W'(BUS_WORDS - 1);
    localparam logic [IDX_W-1:0] DAT_LAST = IDX_W'(DATA_WORDS - 1);
    localparam logic [IDX_W-1:0] ADR_LAST = IDX_W'(ADDR_ITERS - 1);

    bist_state_e      state_n;
    logic [IDX_W-1:0] idx_n;
    logic             hi_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            idx    <= '0;
            hi_pat <= 1'b0;
        end else begin
            state  <= state_n;
            idx    <= idx_n;
            hi_pat <= hi_n;
        end
    end

    always_comb begin
        state_n = state;
        idx_n   = idx;
        hi_n    = hi_pat;
        wr_o    = 1'b0;
        rd_o    = 1'b0;
        load_o  = 1'b0;
        step_o  = 1'b0;
        clr_o   = 1'b0;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    state_n = ST_BUS_WR;
                    idx_n   = '0;
                    hi_n    = 1'b0;
                    clr_o   = 1'b1;
                    load_o  = 1'b1;
                end
            end
            ST_BUS_WR: begin
                wr_o = 1'b1;
                if (idx == BUS_LAST) begin
                    state_n = ST_BUS_RQ;
                    idx_n   = '0;
                end else begin
                    idx_n = idx + 1'b1;
                end
            end
            ST_BUS_RQ: begin
                rd_o    = 1'b1;
                state_n = ST_BUS_WT;
            end
            ST_BUS_WT: begin
                if (rvalid) begin
                    if (idx != BUS_LAST) begin
                        idx_n   = idx + 1'b1;
                        state_n = ST_BUS_RQ;
                    end else if (!hi_pat) begin
                        idx_n   = '0;
                        hi_n    = 1'b1;
                        state_n = ST_BUS_WR;
                    end else begin
                        idx_n   = '0;
                        load_o  = 1'b1;
                        state_n = ST_DAT_WR;
                    end
                end
            end
            ST_DAT_WR: begin
                wr_o   = 1'b1;
                step_o = 1'b1;
                if (idx == DAT_LAST) begin
                    idx_n   = '0;
                    load_o  = 1'b1;
                    state_n = ST_DAT_RQ;
                end else begin
                    idx_n = idx + 1'b1;
                end
            end
            ST_DAT_RQ: begin
                rd_o    = 1'b1;
                state_n = ST_DAT_WT;
            end
            ST_DAT_WT: begin
                if (rvalid) begin
                    step_o = 1'b1;
                    if (idx == DAT_LAST) begin
                        idx_n   = '0;
                        load_o  = 1'b1;
                        state_n = ST_ADR_WR;
                    end else begin
                        idx_n   = idx + 1'b1;
                        state_n = ST_DAT_RQ;
                    end
                end
            end
            ST_ADR_WR: begin
                wr_o   = 1'b1;
                step_o = 1'b1;
                if (idx == ADR_LAST) begin
                    idx_n   = '0;
                    load_o  = 1'b1;
                    state_n = ST_ADR_RQ;
                end else begin
                    idx_n = idx + 1'b1;
                end
            end
            ST_ADR_RQ: begin
                rd_o    = 1'b1;
                state_n = ST_ADR_WT;
            end
            ST_ADR_WT: begin
                if (rvalid) begin
                    step_o = 1'b1;
                    if (idx == ADR_LAST) begin
                        idx_n   = '0;
                        state_n = ST_DONE;
                    end else begin
                        idx_n   = idx + 1'b1;
                        state_n = ST_ADR_RQ;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // R10: the data phase is only entered from the end of the bus phase
    p_phase_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DAT_WR && $past(state) != ST_DAT_WR) |-> $past(state) == ST_BUS_WT);

    // R10: the address phase is only entered from the end of the data phase
    p_addr_after_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADR_WR && $past(state) != ST_ADR_WR) |-> $past(state) == ST_DAT_WT);

endmodule

// File: rtl/mem_bist_engine.sv
module mem_bist_engine #(
    parameter int ADDR_W     = 22,
    parameter int BUS_WORDS  = 128,
    parameter int DATA_WORDS = 524288,
    parameter int ADDR_ITERS = 8192,
    parameter int ERR_W      = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              addr_rand,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_rvalid,
    output logic              done,
    output logic              pass,
    output logic [ERR_W-1:0]  err_bus,
    output logic [ERR_W-1:0]  err_data,
    output logic [ERR_W-1:0]  err_addr
);
    import mbist_pkg::*;

    localparam int MAX_WORDS = (DATA_WORDS > BUS_WORDS)
                             ? ((DATA_WORDS > ADDR_ITERS) ? DATA_WORDS : ADDR_ITERS)
                             : ((BUS_WORDS > ADDR_ITERS) ? BUS_WORDS : ADDR_ITERS);
    localparam int IDX_W     = $clog2(MAX_WORDS + 1);
    localparam int NUM_PH    = 3;

    bist_state_e      state;
    logic [IDX_W-1:0] idx;
    logic             hi_pat, wr, rd, gen_load, gen_step, cnt_clr;
    logic             rnd_mode;
    logic [31:0]      dval;
    logic [15:0]      aval;
    logic [31:0]      expect_w;
    logic             miss;
    logic [NUM_PH-1:0]    ph_inc;
    logic [ERR_W-1:0]     cnt_arr [NUM_PH];

    mbist_fsm #(
        .BUS_WORDS (BUS_WORDS),
        .DATA_WORDS(DATA_WORDS),
        .ADDR_ITERS(ADDR_ITERS),
        .IDX_W     (IDX_W)
    ) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .rvalid(mem_rvalid),
        .state (state),
        .idx   (idx),
        .hi_pat(hi_pat),
        .wr_o  (wr),
        .rd_o  (rd),
        .load_o(gen_load),
        .step_o(gen_step),
        .clr_o (cnt_clr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       rnd_mode <= 1'b0;
        else if (cnt_clr) rnd_mode <= addr_rand;
    end

    mbist_patgen u_gen (
        .clk  (clk),
        .rst_n(rst_n),
        .load (gen_load),
        .step (gen_step),
        .rnd  (rnd_mode),
        .dval (dval),
        .aval (aval)
    );

    always_comb begin
        mem_addr = '0;
        expect_w = '0;
        unique case (state)
            ST_BUS_WR, ST_BUS_RQ, ST_BUS_WT: begin
                mem_addr = ADDR_W'(idx);
                expect_w = hi_pat ? TOGGLE_HI : TOGGLE_LO;
            end
            ST_DAT_WR, ST_DAT_RQ, ST_DAT_WT: begin
                mem_addr = ADDR_W'(idx);
                expect_w = dval;
            end
            ST_ADR_WR, ST_ADR_RQ, ST_ADR_WT: begin
                mem_addr = ADDR_W'(aval);
                expect_w = 32'(idx);
            end
            default: begin
                mem_addr = '0;
                expect_w = '0;
            end
        endcase
    end

    assign mem_we    = wr;
    assign mem_re    = rd;
    assign mem_wdata = wr ? expect_w : '0;

    assign miss = (state == ST_ADR_WT) ? (mem_rdata[15:0] != expect_w[15:0])
                                       : (mem_rdata != expect_w);

    assign ph_inc[0] = (state == ST_BUS_WT) && mem_rvalid && miss;
    assign ph_inc[1] = (state == ST_DAT_WT) && mem_rvalid && miss;
    assign ph_inc[2] = (state == ST_ADR_WT) && mem_rvalid && miss;

    for (genvar g = 0; g < NUM_PH; g++) begin : g_cnt
        mbist_errcnt #(.ERR_W(ERR_W)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (cnt_clr),
            .inc  (ph_inc[g]),
            .cnt  (cnt_arr[g])
        );
    end

    assign err_bus  = cnt_arr[0];
    assign err_data = cnt_arr[1];
    assign err_addr = cnt_arr[2];
    assign done     = (state == ST_DONE);
    assign pass     = done && (err_bus == '0) && (err_data == '0) && (err_addr == '0);

    // R1: results stay frozen after completion until a new start
    p_done_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(err_bus) && $stable(err_data) && $stable(err_addr)));

    // R1: a start pulse launches a run with cleared counts
    p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE || done) && start) |=> (!done && err_bus == '0 && err_data == '0 && err_addr == '0));

    // R3: bus phase accesses stay in the toggle window
    p_bus_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_we || mem_re) && state inside {ST_BUS_WR, ST_BUS_RQ}) |-> (mem_addr < ADDR_W'(BUS_WORDS)));

    // R2: a read waiting for data blocks any new access
    p_one_outstanding_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_BUS_WT, ST_DAT_WT, ST_ADR_WT} && !mem_rvalid) |=> !(mem_re || mem_we));

endmodule

// File: tb/mem_bist_engine_tb.sv
module mem_bist_engine_tb;

    localparam int AW  = 16;
    localparam int BW  = 128;
    localparam int DW  = 256;
    localparam int AI  = 256;
    localparam int EW  = 6;
    localparam int SAT = (1 << EW) - 1;
    localparam int ACC = 2 * BW + DW + AI;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          addr_rand = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic          mem_we, mem_re;
    logic [31:0]   mem_rdata = '0;
    logic          mem_rvalid = 1'b0;
    logic          done, pass;
    logic [EW-1:0] err_bus, err_data, err_addr;

    always #2.5 clk = ~clk;

    mem_bist_engine #(
        .ADDR_W(AW), .BUS_WORDS(BW), .DATA_WORDS(DW), .ADDR_ITERS(AI), .ERR_W(EW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .addr_rand(addr_rand),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .done(done), .pass(pass),
        .err_bus(err_bus), .err_data(err_data), .err_addr(err_addr)
    );

    int checks = 0;
    int errors = 0;

    // fault model: 0 none, 1 stuck-at-0 data bit, 2 address bit alias, 3 one word bit flip
    int ftype = 0;
    int fbit  = 0;
    int faddr = 0;

    function automatic int unsigned fmap(input int unsigned a);
        if (ftype == 2) return a & ~(32'd1 << fbit);
        return a;
    endfunction

    function automatic logic [31:0] fread(input int unsigned a, input logic [31:0] d);
        if (ftype == 1) return d & ~(32'd1 << fbit);
        if (ftype == 3 && a == faddr) return d ^ 32'h8;
        return d;
    endfunction

    function automatic logic [31:0] lcg32(input logic [31:0] x);
        return 32'd1664525 * x + 32'd1013904223;
    endfunction

    function automatic logic [15:0] gen16(input logic [15:0] x, input bit rnd);
        return rnd ? (16'd25173 * x + 16'd13849) : (x + 16'd1);
    endfunction

    // behavioural RAM with random read latency
    logic [31:0] ram [int unsigned];
    bit          pend = 0;
    int          lat = 0;
    int unsigned raddr = 0;
    int          wr_cnt = 0, rd_cnt = 0, viol = 0;
    logic [31:0] first_dat_wd = '0, first_adr_wd = '0;
    int unsigned first_dat_a = 0, first_adr_a = 0;

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_we && mem_re) viol++;
        if (mem_re && pend) viol++;
        if (mem_we) begin
            if (wr_cnt == 2 * BW) begin first_dat_wd = mem_wdata; first_dat_a = mem_addr; end
            if (wr_cnt == 2 * BW + DW) begin first_adr_wd = mem_wdata; first_adr_a = mem_addr; end
            ram[fmap(mem_addr)] = mem_wdata;
            wr_cnt++;
        end
        if (pend) begin
            if (lat == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= fread(raddr, ram.exists(fmap(raddr)) ? ram[fmap(raddr)] : 32'h0);
                pend = 0;
            end else lat--;
        end
        if (mem_re) begin
            pend  = 1;
            lat   = $urandom_range(0, 2);
            raddr = mem_addr;
            rd_cnt++;
        end
    end

    // expected counts from the requirements (R3, R4, R5, R6, R7)
    logic [31:0] mm [int unsigned];

    function automatic logic [31:0] mrd(input int unsigned a);
        return fread(a, mm.exists(fmap(a)) ? mm[fmap(a)] : 32'h0);
    endfunction

    task automatic model(input bit rnd, output int eb, output int ed, output int ea);
        logic [31:0] x;
        logic [15:0] g;
        logic [31:0] pat;
        mm.delete();
        eb = 0; ed = 0; ea = 0;
        for (int p = 0; p < 2; p++) begin
            pat = (p == 0) ? 32'hAAAAAAAA : 32'h55555555;
            for (int i = 0; i < BW; i++) mm[fmap(i)] = pat;
            for (int i = 0; i < BW; i++) if (mrd(i) != pat) eb++;
        end
        x = 0;
        for (int i = 0; i < DW; i++) begin x = lcg32(x); mm[fmap(i)] = x; end
        x = 0;
        for (int i = 0; i < DW; i++) begin x = lcg32(x); if (mrd(i) != x) ed++; end
        g = 0;
        for (int i = 0; i < AI; i++) begin g = gen16(g, rnd); mm[fmap(g)] = i; end
        g = 0;
        for (int i = 0; i < AI; i++) begin g = gen16(g, rnd); if (mrd(g) % 65536 != i % 65536) ea++; end
        if (eb > SAT) eb = SAT;
        if (ed > SAT) ed = SAT;
        if (ea > SAT) ea = SAT;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_case(input bit rnd, input int ft, input int fb, input int fa,
                            input bit mid_start);
        int eb, ed, ea, wait_cyc;
        logic [EW-1:0] hb, hd, ha;
        bit timeout;
        ftype = ft; fbit = fb; faddr = fa;
        ram.delete();
        model(rnd, eb, ed, ea);
        @(negedge clk);
        wr_cnt = 0; rd_cnt = 0; viol = 0;
        addr_rand = rnd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        addr_rand = ~rnd;
        chk(!done, "R1", "done low during run", done, 0);
        wait_cyc = 0;
        timeout = 0;
        while (!done) begin
            @(negedge clk);
            wait_cyc++;
            if (mid_start && wait_cyc == 300) start = 1'b1;
            else start = 1'b0;
            if (wait_cyc > 20000) begin timeout = 1; break; end
        end
        chk(!timeout, "R1", "watchdog, run finished", timeout, 0);
        chk(err_bus == eb,  "R3", "bus errors",  err_bus,  eb);
        chk(err_data == ed, "R4", "data errors", err_data, ed);
        chk(err_addr == ea, "R5", "addr errors", err_addr, ea);
        if (eb == SAT || ed == SAT || ea == SAT)
            chk(1'b1 && (err_bus == eb), "R7", "saturated count", err_bus, eb);
        chk(pass == (eb == 0 && ed == 0 && ea == 0), "R8", "pass", pass, (eb == 0 && ed == 0 && ea == 0));
        chk(wr_cnt == ACC, "R2", "write count", wr_cnt, ACC);
        chk(rd_cnt == ACC, "R2", "read count", rd_cnt, ACC);
        chk(viol == 0, "R2", "access overlap", viol, 0);
        chk(first_dat_wd == 32'h3C6EF35F && first_dat_a == 0, "R4", "first data write",
            first_dat_wd, 32'h3C6EF35F);
        chk(first_adr_wd == 0 && first_adr_a == (rnd ? 13849 : 1), "R6", "first addr-phase address",
            first_adr_a, rnd ? 13849 : 1);
        chk(first_adr_a != 0 || first_dat_a == 0, "R10", "phase order via write index",
            first_adr_a, rnd ? 13849 : 1);
        hb = err_bus; hd = err_data; ha = err_addr;
        repeat (15) @(negedge clk);
        chk(done && err_bus == hb && err_data == hd && err_addr == ha, "R1", "results held",
            err_bus, hb);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        chk(!done && !pass && !mem_we && !mem_re, "R9", "reset outputs", done, 0);
        chk(err_bus == 0 && err_data == 0 && err_addr == 0, "R9", "reset counts",
            err_bus + err_data + err_addr, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!done && !mem_we && !mem_re, "R9", "idle after reset", mem_we, 0);

        run_case(0, 0, 0, 0, 0);       // clean, sequential
        run_case(1, 0, 0, 0, 1);       // clean, random, start mid-run ignored (R1)
        run_case(0, 1, 0, 0, 0);       // stuck bit: saturation (R7)
        run_case(0, 2, 7, 0, 0);       // address alias caught by R5
        run_case(1, 3, 0, 5, 0);       // single corrupted word
        for (int k = 0; k < 3; k++) begin
            int t;
            t = $urandom_range(0, 3);
            run_case($urandom_range(0, 1), t, $urandom_range(0, 7), $urandom_range(0, BW - 1), 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule